// File: doc/BRIEF.md
# Configurable-Order Word Serializer with Squelch

This block converts parallel words into a serial bit stream, one bit per cycle of the serial bit clock. It pulls each word from the read port of an upstream FIFO, which presents its head word before the pop. It also produces a word-rate clock by dividing the bit clock by the current word length. A mode input selects 4-bit words, which use only the low four lanes, or 16-bit words. An order input selects whether the least or the most significant bit of each word goes out first. Word width and order are captured when a word is loaded, so the next word follows the last bit of the previous one with no idle cycle.

An active-low squelch forces the serial output to zero so that corrupted data does not reach the line. Squelch is ignored while the active-low line loopback control is asserted. An active-low diagnostic loopback control routes the unsquelched serializer bit to the receive-side deserializer input. Otherwise that input carries the external line data. Asserting both loopbacks together is not a supported setup. The block flags it on a status output, and diagnostic loopback takes precedence.

Top module: `serial_tx_shifter`

## Requirements
- R1: While `rstN` is low, `serOut`, `fifoRead` and `wordClk` are 0. The first word load happens on the first clock edge after `rstN` rises, and `fifoRead` is high in the cycle before that edge.
- R2: `fifoRead` pulses for one cycle per word, every 16 cycles in 16-bit mode and every 4 cycles in 4-bit mode. The first bit of a new word appears in the cycle right after the last bit of the previous word.
- R3: With `wide16`=1 all 16 bits of `fifoData` are sent. With `wide16`=0 only `fifoData[3:0]` are sent, and bits 15..4 have no effect on the output.
- R4: With `msbFirst`=0 the word goes out as bit 0 first, then bit 1, and so on in ascending order up to bit 15 (or bit 3).
- R5: With `msbFirst`=1 the word goes out as bit 15 (or bit 3 in 4-bit mode) first, in descending order, ending with bit 0.
- R6: `wide16` and `msbFirst` are sampled only at the load edge of a word. Changing them in the middle of a word does not alter that word.
- R7: While `squelchN`=0 and `lineLoopN`=1, `serOut` is 0. Word sequencing continues unaffected.
- R8: While `lineLoopN`=0, `squelchN` has no effect and `serOut` carries the serializer bit.
- R9: While `diagLoopN`=0, `deserIn` equals the unsquelched serializer bit. While `diagLoopN`=1, `deserIn` equals `rxLineIn`.
- R10: `loopConflict` is 1 exactly when `diagLoopN` and `lineLoopN` are both 0. In that state `deserIn` follows the serializer.
- R11: `wordClk` is high for the first half of each word period (8 of 16 bits, or 2 of 4 bits) and low for the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wide16 | input | 1 | 1: 16-bit words, 0: 4-bit words |
| msbFirst | input | 1 | 1: top bit first, 0: bit 0 first |
| squelchN | input | 1 | Active-low output squelch |
| lineLoopN | input | 1 | Active-low line loopback control (disables squelch) |
| diagLoopN | input | 1 | Active-low diagnostic loopback control |
| fifoData | input | 16 | Head word of the FIFO read port |
| rxLineIn | input | 1 | Serial data from the line for the deserializer |
| fifoRead | output | 1 | Pop strobe to the FIFO, one cycle per word |
| wordClk | output | 1 | Word-rate clock, bit clock divided by word length |
| serOut | output | 1 | Serial data output |
| deserIn | output | 1 | Serial data to the deserializer input |
| loopConflict | output | 1 | Both loopbacks asserted |

## Verification
The serializer is driven with several word patterns:
- alternating, single-end and all-ones words, which separate the two bit orders;
- zero and random words, which catch shift or lane-select errors;
- narrow words with busy upper lanes, which expose any leak of bits 15..4.

Width and order are switched both at word boundaries and in the middle of a word, which tells load-time capture apart from live use. Squelch is exercised with line loopback both off and on, and the two loopbacks are exercised alone and together against a toggling line input. A second reset in mid-stream confirms that the output returns to idle and that the first load starts cleanly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Strobes passed from the sequencing control to the shift datapath.
  typedef struct packed {
    logic load;      // capture a new word this edge
    logic shift;     // advance by one bit this edge
    logic wide;      // word width for the word being loaded
    logic msbFirst;  // bit order for the word being loaded
  } ctrlStrobes_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wide16,
  input  logic         msbFirst,
  output ctrlStrobes_t strb,
  output logic         fifoRead,
  output logic         wordClk
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);
  localparam logic [CNT_W-1:0] WIDE_HALF   = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] NARROW_HALF = CNT_W'(NARROW_W / 2);

  logic             primed;
  logic             wideReg;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] halfIdx;
  logic             atEnd;

  assign lastIdx = wideReg ? WIDE_LAST : NARROW_LAST;
  assign halfIdx = wideReg ? WIDE_HALF : NARROW_HALF;
  assign atEnd   = !primed || (bitCnt == lastIdx);

  always_comb begin
    strb.load     = atEnd;
    strb.shift    = !atEnd;
    strb.wide     = wide16;
    strb.msbFirst = msbFirst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed  <= 1'b0;
      wideReg <= 1'b0;
      bitCnt  <= '0;
    end else if (atEnd) begin
      primed  <= 1'b1;
      wideReg <= wide16;
      bitCnt  <= '0;
    end else begin
      bitCnt  <= bitCnt + CNT_W'(1);
    end
  end

  assign fifoRead = rstN && atEnd;
  assign wordClk  = primed && (bitCnt < halfIdx);

  // R2: a pop is followed by bit position zero of the new word
  p_gap_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |=> (primed && bitCnt == '0));

  // R2: the bit counter never passes the last position of the captured width
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= lastIdx);

  // R2: between pops the position advances by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fifoRead) |=> (bitCnt == $past(bitCnt) + CNT_W'(1)));

  // R6: the width captured for a word stays fixed until the next pop
  p_width_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fifoRead) |=> $stable(wideReg));

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] word,
  output logic              serBit
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] wideOrd;
  logic [WORD_W-1:0] narrowOrd;

  // Reorder at load so the first bit to send always sits in lane zero.
  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    assign wideOrd[i] = strb.msbFirst ? word[WORD_W-1-i] : word[i];
    if (i < NARROW_W) begin : g_low
      assign narrowOrd[i] = strb.msbFirst ? word[NARROW_W-1-i] : word[i];
    end else begin : g_high
      assign narrowOrd[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= strb.wide ? wideOrd : narrowOrd;
    end else if (strb.shift) begin
      shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
    end
  end

  assign serBit = shiftReg[0];

  // R4: each non-load edge moves the word down by one lane
  p_shift_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=> (shiftReg == ($past(shiftReg) >> 1)));

  // R3: a narrow load leaves the upper lanes empty
  p_narrow_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.wide) |=> (shiftReg[WORD_W-1:NARROW_W] == '0));

  // R2: load and shift are never requested together
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.shift));

endmodule

// File: rtl/sertx_outmux.sv
module sertx_outmux (
  input  logic clk,
  input  logic rstN,
  input  logic serBit,
  input  logic squelchN,
  input  logic lineLoopN,
  input  logic diagLoopN,
  input  logic rxLineIn,
  output logic serOut,
  output logic deserIn,
  output logic loopConflict
);

  logic squelchActive;
  logic diagActive;

  assign squelchActive = !squelchN && lineLoopN;
  assign diagActive    = !diagLoopN;

  assign serOut       = squelchActive ? 1'b0 : serBit;
  assign deserIn      = diagActive ? serBit : rxLineIn;
  assign loopConflict = !diagLoopN && !lineLoopN;

  // R7: squelched output carries no ones
  p_squelch_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!squelchN && lineLoopN) |-> !serOut);

  // R8: line loopback lets the serializer bit through regardless of squelch
  p_line_override_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lineLoopN |-> (serOut == serBit));

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
  import sertx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide16,
  input  logic              msbFirst,
  input  logic              squelchN,
  input  logic              lineLoopN,
  input  logic              diagLoopN,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              rxLineIn,
  output logic              fifoRead,
  output logic              wordClk,
  output logic              serOut,
  output logic              deserIn,
  output logic              loopConflict
);

  ctrlStrobes_t strb;
  logic         serBit;

  sertx_ctrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wide16   (wide16),
    .msbFirst (msbFirst),
    .strb     (strb),
    .fifoRead (fifoRead),
    .wordClk  (wordClk)
  );

  sertx_dp #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .word   (fifoData),
    .serBit (serBit)
  );

  sertx_outmux u_mux (
    .clk          (clk),
    .rstN         (rstN),
    .serBit       (serBit),
    .squelchN     (squelchN),
    .lineLoopN    (lineLoopN),
    .diagLoopN    (diagLoopN),
    .rxLineIn     (rxLineIn),
    .serOut       (serOut),
    .deserIn      (deserIn),
    .loopConflict (loopConflict)
  );

  // R10: with both loopbacks asserted the deserializer still sees the serializer
  p_conflict_diag_r10: assert property (@(posedge clk) disable iff (!rstN)
    loopConflict |-> (deserIn == serBit));

endmodule

// File: tb/test_serial_tx_shifter.sv
module test_serial_tx_shifter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wide16 = 1'b1;
  logic        msbFirst = 1'b0;
  logic        squelchN = 1'b1;
  logic        lineLoopN = 1'b1;
  logic        diagLoopN = 1'b1;
  logic [15:0] fifoData = 16'h0000;
  logic        rxLineIn = 1'b0;
  logic        fifoRead, wordClk, serOut, deserIn, loopConflict;

  int checks = 0;
  int failures = 0;
  string phaseTag = "R1";

  // behavioural reference state
  int  bitQ[$];
  bit  started = 0;
  int  curW = 0;
  int  wordIdx = 0;

  always #4 clk = ~clk;

  serial_tx_shifter i_serial_tx_shifter (
    .clk(clk), .rstN(rstN), .wide16(wide16), .msbFirst(msbFirst),
    .squelchN(squelchN), .lineLoopN(lineLoopN), .diagLoopN(diagLoopN),
    .fifoData(fifoData), .rxLineIn(rxLineIn), .fifoRead(fifoRead),
    .wordClk(wordClk), .serOut(serOut), .deserIn(deserIn),
    .loopConflict(loopConflict)
  );

  function automatic logic [15:0] nextWord(int idx);
    case (idx)
      0: return 16'hA5C3;
      1: return 16'h8001;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h1234;
      5: return 16'h7FFE;
      default: return 16'($urandom());
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one bit-clock cycle: compare at negedge+1, then advance the model
  task automatic step();
    bit   loadNow;
    logic raw, expSer, expRead, expWclk, expDes, expConf;
    #1;
    if (!rstN) begin
      check("R1", "serOut", serOut, 1'b0);
      check("R1", "fifoRead", fifoRead, 1'b0);
      check("R1", "wordClk", wordClk, 1'b0);
      @(negedge clk);
      return;
    end
    loadNow = !started || (bitQ.size() == 1);
    raw     = started ? logic'(bitQ[0]) : 1'b0;
    expSer  = (squelchN || !lineLoopN) ? raw : 1'b0;
    expRead = loadNow;
    expWclk = started && ((curW - bitQ.size()) < curW / 2);
    expDes  = !diagLoopN ? raw : rxLineIn;
    expConf = !diagLoopN && !lineLoopN;
    check(phaseTag, "serOut", serOut, expSer);
    check("R2", "fifoRead", fifoRead, expRead);
    check("R11", "wordClk", wordClk, expWclk);
    check("R9", "deserIn", deserIn, expDes);
    check("R10", "loopConflict", loopConflict, expConf);
    if (loadNow) begin
      curW = wide16 ? 16 : 4;
      bitQ.delete();
      for (int k = 0; k < curW; k++) begin
        int pos;
        pos = msbFirst ? (curW - 1 - k) : k;
        bitQ.push_back(int'(fifoData[pos]));
      end
      started = 1;
    end else begin
      void'(bitQ.pop_front());
    end
    @(negedge clk);
    if (loadNow) begin
      wordIdx++;
      fifoData = nextWord(wordIdx);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic toBoundary();
    while (started && bitQ.size() != 1) step();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fifoData = nextWord(0);
    @(negedge clk);
    phaseTag = "R1";
    run(3);
    rstN = 1'b1;
    // R4, R3: wide, LSB first
    phaseTag = "R4";
    run(64);
    // R5: wide, MSB first, switched at a boundary
    toBoundary(); msbFirst = 1'b1; phaseTag = "R5";
    run(64);
    // R3: narrow words, upper lanes busy, both orders
    toBoundary(); wide16 = 1'b0; phaseTag = "R3";
    run(24);
    toBoundary(); msbFirst = 1'b0;
    run(24);
    // R6: mid-word changes of width and order
    toBoundary(); wide16 = 1'b1; phaseTag = "R6";
    run(5);  msbFirst = 1'b1; wide16 = 1'b0;
    run(3);  msbFirst = 1'b0; wide16 = 1'b1;
    run(40);
    step(); msbFirst = 1'b1;
    run(2); wide16 = 1'b0;
    run(30);
    // R7: squelch with line loopback off
    squelchN = 1'b0; phaseTag = "R7";
    run(20);
    // R8: squelch ignored under line loopback
    lineLoopN = 1'b0; phaseTag = "R8";
    run(20);
    lineLoopN = 1'b1; squelchN = 1'b1; wide16 = 1'b1;
    // R9: diagnostic loopback, line input toggling
    phaseTag = "R9";
    for (int i = 0; i < 24; i++) begin rxLineIn = logic'(i % 3 == 0); step(); end
    diagLoopN = 1'b0;
    for (int i = 0; i < 24; i++) begin rxLineIn = logic'(i % 2); step(); end
    squelchN = 1'b0;
    run(12);
    // R10: both loopbacks asserted
    lineLoopN = 1'b0; phaseTag = "R10";
    for (int i = 0; i < 20; i++) begin rxLineIn = logic'(i % 2); step(); end
    diagLoopN = 1'b1; lineLoopN = 1'b1; squelchN = 1'b1;
    run(10);
    // R1: reset in mid-stream and clean restart
    rstN = 1'b0; started = 0; bitQ.delete(); phaseTag = "R1";
    run(3);
    rstN = 1'b1; phaseTag = "R2";
    run(40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule